// File: doc/BRIEF.md
# Memory Write-Protection Gate

This block sits between the serial command decoder and the storage of a byte-addressed nonvolatile memory. It holds the write-enable latch and decides, cycle by cycle, whether the byte the decoder is about to commit may go into the array or into the status register. The decoder supplies one-cycle strobes for the start and end of a chip-select transaction, for the enable and disable commands, and for the completion of a write. It also supplies the current protect-enable bit, the two block-protect bits, the hardware write-protect pin (active low) and the byte address. The decoder increments that address as a burst proceeds.

The block produces two registered permits, one for array writes and one for status-register writes. A small state machine tracks whether a transaction is open. Its states are ST_IDLE and ST_OPEN. The transition ST_IDLE to ST_OPEN is taken on a start strobe, and ST_OPEN to ST_IDLE is taken on an end strobe. On the ST_IDLE to ST_OPEN transition the level of the hardware pin is sampled and held. It is not sampled again until the next transaction starts. Both permits stay low while no transaction is open.

Top module: `wp_gate`

## Requirements
- R1: While the write-enable latch is 0, both permits are 0 for every address and every setting of the other inputs.
- R2: Block-protect code 00 protects nothing, 01 protects 6000h–7FFFh, 10 protects 4000h–7FFFh and 11 protects 0000h–7FFFh. The array permit is 0 for any address inside the chosen range, whatever the latch, pin and protect-enable levels are.
- R3: With the latch at 1 and a transaction open, the array permit is 1 for an address outside the protected range.
- R4: With the latch at 1, protect-enable at 0 and a transaction open, the status-register permit is 1 whatever the level of the pin.
- R5: With the latch at 1, protect-enable at 1 and a transaction open, the status-register permit equals the pin level sampled at the start of the transaction (1 = high).
- R6: A change of the pin while a transaction is open leaves the status-register permit unchanged until the next start strobe.
- R7: The latch is set by the enable strobe. It is cleared by the disable strobe or the write-complete strobe. When a clearing strobe and the enable strobe arrive in the same cycle, the latch ends up cleared.
- R8: The permits are registered. Each permit reflects the address and state present at the previous clock edge, so it follows a new address on every cycle of a burst. Both permits are 0 in ST_IDLE.
- R9: During and immediately after reset the latch is 0, both permits are 0 and the state is ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xact_start | input | 1 | One-cycle strobe: chip select fell |
| xact_end | input | 1 | One-cycle strobe: chip select rose |
| wren | input | 1 | One-cycle strobe: write-enable command |
| wrdi | input | 1 | One-cycle strobe: write-disable command |
| wr_done | input | 1 | One-cycle strobe: a write transaction completed |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| wpen | input | 1 | Status-register protect-enable bit |
| bp | input | 2 | Block-protect code |
| addr | input | AW (15) | Byte address of the pending write |
| wel | output | 1 | Write-enable latch |
| arr_wr_ok | output | 1 | Array write permitted for addr |
| sr_wr_ok | output | 1 | Status-register write permitted |

## Verification
The latch changes at the clock edge that sees its strobe. Each permit changes one edge after the inputs it depends on, so a start strobe followed by one idle edge gives the first valid permit. The bench drives all inputs on the falling clock edge. It lets exactly those edges pass before sampling on a later falling edge: two edges after a latch strobe, one edge after a start strobe, and one edge per new burst address. An end strobe needs two edges before the permits are checked at zero.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OPEN = 1'b1
    } xact_st_t;

    typedef logic [1:0] bp_code_t;
endpackage

// File: rtl/wpg_wel.sv
module wpg_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic wren,
    input  logic wrdi,
    input  logic wr_done,
    output logic wel
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            wel <= 1'b0;
        else if (wrdi || wr_done)
            wel <= 1'b0;
        else if (wren)
            wel <= 1'b1;
    end

    // R7: a clearing strobe always wins
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wrdi || wr_done) |=> !wel);
    a_r7_set_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (wren && !wrdi && !wr_done) |=> wel);
endmodule

// File: rtl/wpg_range.sv
module wpg_range
    import wpg_pkg::*;
#(
    parameter int unsigned AW = 15
) (
    input  bp_code_t         bp,
    input  logic [AW-1:0]    addr,
    output logic             prot
);
    localparam int unsigned DEPTH = 32'd1 << AW;

    int unsigned span;

    always_comb begin
        unique case (bp)
            2'b01:   span = DEPTH >> 2;
            2'b10:   span = DEPTH >> 1;
            2'b11:   span = DEPTH;
            default: span = 0;
        endcase
        prot = (span != 0) && (32'(addr) >= (DEPTH - span));
    end
endmodule

// File: rtl/wpg_xact.sv
module wpg_xact
    import wpg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     stop,
    input  logic     wp_n,
    output xact_st_t state,
    output logic     wp_lat
);
    xact_st_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_OPEN;
            ST_OPEN: if (stop)  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs: pin level sampled on the idle-to-open transition
    always_ff @(posedge clk) begin
        if (!rst_n)
            wp_lat <= 1'b0;
        else if (state == ST_IDLE && start)
            wp_lat <= wp_n;
    end

    // R6: sampled pin frozen while a transaction is open
    a_r6_pin_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN) |=> $stable(wp_lat));
endmodule

// File: rtl/wp_gate.sv
module wp_gate
    import wpg_pkg::*;
#(
    parameter int unsigned AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xact_start,
    input  logic          xact_end,
    input  logic          wren,
    input  logic          wrdi,
    input  logic          wr_done,
    input  logic          wp_n,
    input  logic          wpen,
    input  logic [1:0]    bp,
    input  logic [AW-1:0] addr,
    output logic          wel,
    output logic          arr_wr_ok,
    output logic          sr_wr_ok
);
    xact_st_t state;
    logic     wp_lat;
    logic     prot;

    wpg_wel u_wel (
        .clk(clk), .rst_n(rst_n), .wren(wren), .wrdi(wrdi),
        .wr_done(wr_done), .wel(wel)
    );

    wpg_range #(.AW(AW)) u_range (
        .bp(bp), .addr(addr), .prot(prot)
    );

    wpg_xact u_xact (
        .clk(clk), .rst_n(rst_n), .start(xact_start), .stop(xact_end),
        .wp_n(wp_n), .state(state), .wp_lat(wp_lat)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_wr_ok <= 1'b0;
            sr_wr_ok  <= 1'b0;
        end else begin
            arr_wr_ok <= (state == ST_OPEN) && wel && !prot;
            sr_wr_ok  <= (state == ST_OPEN) && wel && (!wpen || wp_lat);
        end
    end

    a_r1_no_permit_without_wel: assert property (@(posedge clk) disable iff (!rst_n)
        !wel |=> (!arr_wr_ok && !sr_wr_ok));
    a_r2_protected_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        prot |=> !arr_wr_ok);
    a_r4_sr_open_when_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && wel && !wpen) |=> sr_wr_ok);
    a_r8_idle_no_permit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (!arr_wr_ok && !sr_wr_ok));
endmodule

// File: tb/wp_gate_tb.sv
`timescale 1ns/1ps
module wp_gate_tb;
    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xact_start = 0, xact_end = 0, wren = 0, wrdi = 0, wr_done = 0;
    logic          wp_n = 1, wpen = 0;
    logic [1:0]    bp = 2'b00;
    logic [AW-1:0] addr = '0;
    logic          wel, arr_wr_ok, sr_wr_ok;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    wp_gate #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .xact_start(xact_start), .xact_end(xact_end),
        .wren(wren), .wrdi(wrdi), .wr_done(wr_done), .wp_n(wp_n), .wpen(wpen),
        .bp(bp), .addr(addr), .wel(wel), .arr_wr_ok(arr_wr_ok), .sr_wr_ok(sr_wr_ok)
    );

    // vector: wel, wpen, bp[1:0], wp_n, addr[14:0], exp_arr, exp_sr
    localparam int NV = 12;
    localparam logic [21:0] VEC [NV] = '{
        {1'b0, 1'b0, 2'b00, 1'b1, 15'h0000, 1'b0, 1'b0},  // R1
        {1'b0, 1'b0, 2'b00, 1'b1, 15'h1234, 1'b0, 1'b0},  // R1
        {1'b1, 1'b0, 2'b00, 1'b0, 15'h7FFF, 1'b1, 1'b1},  // R3 R4
        {1'b1, 1'b0, 2'b01, 1'b1, 15'h6000, 1'b0, 1'b1},  // R2
        {1'b1, 1'b0, 2'b01, 1'b1, 15'h5FFF, 1'b1, 1'b1},  // R3
        {1'b1, 1'b1, 2'b10, 1'b0, 15'h4000, 1'b0, 1'b0},  // R2 R5
        {1'b1, 1'b1, 2'b10, 1'b1, 15'h3FFF, 1'b1, 1'b1},  // R3 R5
        {1'b1, 1'b1, 2'b11, 1'b1, 15'h0000, 1'b0, 1'b1},  // R2 R5
        {1'b1, 1'b1, 2'b11, 1'b0, 15'h7FFF, 1'b0, 1'b0},  // R2 R5
        {1'b0, 1'b1, 2'b00, 1'b1, 15'h0100, 1'b0, 1'b0},  // R1
        {1'b1, 1'b0, 2'b10, 1'b0, 15'h7000, 1'b0, 1'b1},  // R2 R4
        {1'b1, 1'b1, 2'b00, 1'b0, 15'h2000, 1'b1, 1'b0}   // R3 R5
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        xact_start = 0; xact_end = 0; wren = 0; wrdi = 0; wr_done = 0;
    endtask

    task automatic open_xact(input logic pin);
        xact_end = 1; tick();
        wp_n = pin; xact_start = 1; tick();
        tick();
    endtask

    initial begin
        #(5.0 * 20000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 during reset
        chk("R9", "wel in reset", wel, 1'b0);
        chk("R9", "arr in reset", arr_wr_ok, 1'b0);
        chk("R9", "sr in reset", sr_wr_ok, 1'b0);
        rst_n = 1;
        tick();
        chk("R9", "wel after reset", wel, 1'b0);
        chk("R8", "arr idle", arr_wr_ok, 1'b0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            xact_end = 1; tick();
            if (VEC[i][21]) wren = 1; else wrdi = 1;
            tick();
            wpen = VEC[i][20]; bp = VEC[i][19:18]; addr = VEC[i][16:2];
            wp_n = VEC[i][17]; xact_start = 1; tick();
            tick();
            chk("R7", $sformatf("vec %0d wel", i), wel, VEC[i][21]);
            chk("R1/R2/R3", $sformatf("vec %0d arr", i), arr_wr_ok, VEC[i][1]);
            chk("R4/R5", $sformatf("vec %0d sr", i), sr_wr_ok, VEC[i][0]);
        end

        // R6: pin change mid-transaction has no effect until next start
        wren = 1; tick();
        wpen = 1; bp = 2'b00; addr = 15'h0010;
        open_xact(1'b1);
        chk("R5", "sr with pin high", sr_wr_ok, 1'b1);
        wp_n = 0; tick(); tick();
        chk("R6", "sr after mid pin drop", sr_wr_ok, 1'b1);
        open_xact(1'b0);
        chk("R6", "sr after new start pin low", sr_wr_ok, 1'b0);
        wp_n = 1; tick(); tick();
        chk("R6", "sr after mid pin rise", sr_wr_ok, 1'b0);

        // R8: burst across the quarter boundary
        bp = 2'b01; wpen = 0;
        open_xact(1'b1);
        addr = 15'h5FFE; tick();
        chk("R8", "burst 5FFE", arr_wr_ok, 1'b1);
        addr = 15'h5FFF; tick();
        chk("R8", "burst 5FFF", arr_wr_ok, 1'b1);
        addr = 15'h6000; tick();
        chk("R8", "burst 6000", arr_wr_ok, 1'b0);
        addr = 15'h0000; tick();
        chk("R8", "burst wrap 0000", arr_wr_ok, 1'b1);
        xact_end = 1; tick(); tick();
        chk("R8", "arr after end", arr_wr_ok, 1'b0);
        chk("R8", "sr after end", sr_wr_ok, 1'b0);

        // R7: write-complete clears, clear wins over enable
        chk("R7", "wel before done", wel, 1'b1);
        wr_done = 1; tick();
        chk("R7", "wel after wr_done", wel, 1'b0);
        wren = 1; tick();
        chk("R7", "wel set", wel, 1'b1);
        wren = 1; wrdi = 1; tick();
        chk("R7", "wel wren+wrdi", wel, 1'b0);
        wren = 1; tick();
        wren = 1; wr_done = 1; tick();
        chk("R7", "wel wren+wr_done", wel, 1'b0);

        // R1: latch cleared inside an open transaction
        wren = 1; tick();
        bp = 2'b00;
        open_xact(1'b1);
        chk("R3", "arr open with wel", arr_wr_ok, 1'b1);
        wrdi = 1; tick(); tick();
        chk("R1", "arr after wrdi", arr_wr_ok, 1'b0);
        chk("R1", "sr after wrdi", sr_wr_ok, 1'b0);

        // R9: reset mid-transaction
        wren = 1; tick();
        open_xact(1'b1);
        rst_n = 0; tick();
        chk("R9", "wel after reset pulse", wel, 1'b0);
        chk("R9", "arr after reset pulse", arr_wr_ok, 1'b0);
        rst_n = 1; tick();
        chk("R9", "sr after reset release", sr_wr_ok, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule